// File: doc/BRIEF.md
# EDID I2C Controller Register Model

This block is a fully emulated display I2C controller that answers only display identification (EDID) reads. Software talks to it through four 32-bit registers on a simple read/write bus: a pin-pair select register, a command register, a status register and a data register. The EDID bytes come from an internal 128-byte store that is filled through a load port after reset. No I2C pins are driven and no bus timing is modelled. The controller is always ready, and a transfer moves straight from command to data phase, and then to wait or idle.

Software selects a pin pair, then writes a command with a byte count, a 7-bit target address, an optional start index and a cycle type. It then reads the data register repeatedly. Each read returns up to four EDID bytes packed little-endian. The last read of a transfer closes it. The status register reports the transfer phase, the error flag for an absent display, and an in-use semaphore that software can claim and release.

Top module: `edid_regs_top`

## Requirements
- R1: After reset, a status read returns 0x09. The status word has ready at bit 0 (always 1), active at bit 1, wait at bit 2, timeout error at bit 3, in-use at bit 4 and the phase at bits 6:5 (0 idle, 1 data, 2 wait); all other bits are 0.
- R2: Register offsets on bus_addr_i are 0 select, 1 command, 2 status and 3 data. bus_rdata_o takes the read value at the clock edge that samples bus_rd_i and otherwise holds. A write in the same cycle takes priority, and the read is then ignored.
- R3: In the select register, pin codes 5, 4, 6 and 2 pick monitor_present_i bits 0, 1, 2 and 3. Writing any value stores it, resets the EDID transfer state (target selection, EDID availability, pointer, count, cycle) and sets the phase to idle. A valid code also clears active, sets wait, and makes EDID available with the timeout error clear if that display is present; if it is absent, the timeout error is set. Code 0 and the other codes leave the status flags unchanged.
- R4: Command fields: bit 0 is the read direction, bits 7:1 the target, bits 15:8 the index, bits 24:16 the byte count, bits 27:25 the cycle, bit 30 software-ready and bit 31 clear-interrupt. Bit 30 always reads back as 0.
- R5: Only target 0x50 selects the EDID source, and other targets leave it unselected. When cycle bit 26 is set, the read pointer loads from the index field.
- R6: Cycle codes 1, 3, 5 and 7 set the data phase and set active. Code 4 (stop) resets the EDID transfer state, sets the phase to idle and clears active, but only if the cycle code stored before this write was non-zero. Codes 0, 2 and 6 do not change the phase.
- R7: A data read with the read direction set and N = count - pointer > 0 fills byte lanes 0 to min(4, N)-1 (lane i at bits 8i+7:8i) with successive EDID bytes. The upper lanes keep their previous contents.
- R8: When a data read starts with N <= 4, the phase becomes idle for cycles 5 and 7 and wait otherwise, and the EDID transfer state resets.
- R9: A byte returns 0 and the pointer does not advance when no target is selected, no EDID is available, or the pointer is 128 or more.
- R10: A data read with N <= 0, or with the read direction clear, returns the last data-register value.
- R11: A status read returns the value before the read and then sets in-use. A status write with bit 4 set clears in-use. All other status bits ignore writes.
- R12: Writing a command with bit 31 set while the stored bit 31 is clear stores the command normally. While the stored bit 31 is set, command writes with bit 31 set are ignored. A write with bit 31 clear clears only the stored bit 31 and resets the status to ready, plus the timeout error if no EDID is available, with the phase idle.
- R13: Writes to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| monitor_present_i | input | 4 | Display present on each port |
| load_we_i | input | 1 | EDID store write enable |
| load_addr_i | input | 7 | EDID store byte address |
| load_data_i | input | 8 | EDID store byte |

## Verification
The main read path is exercised with several transfers. An indexed transfer of ten bytes shows that packing continues across full and partial words and that the closing read picks idle. A four-byte transfer with no stop picks the wait phase. A transfer that starts two bytes below the end of the store separates the lanes that are served from the lanes that return zero without advancing. Transfers with an absent display, a wrong target and a clear direction bit show that each guard alone blocks data. A stop issued after a stored "no cycle" code is also checked, to tell the conditional stop apart from an unconditional one.

// File: rtl/edid_i2c_pkg.sv
package edid_i2c_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  localparam logic [1:0] REG_SEL  = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CMD_DIR_BIT      = 0;
  localparam int CMD_TGT_LSB      = 1;
  localparam int CMD_IDX_LSB      = 8;
  localparam int CMD_CNT_LSB      = 16;
  localparam int CMD_CYC_LSB      = 25;
  localparam int CMD_IDX_CYC_BIT  = 26;
  localparam int CMD_SW_READY_BIT = 30;
  localparam int CMD_SW_CLR_BIT   = 31;

  localparam int ST_IN_USE_BIT = 4;

  localparam logic [2:0] CYC_NONE = 3'd0;
  localparam logic [2:0] CYC_STOP = 3'd4;

  // odd codes carry a data phase
  function automatic logic cyc_is_data(logic [2:0] c);
    return c[0];
  endfunction

  function automatic logic cyc_ends_idle(logic [2:0] c);
    return c[2] & c[0];
  endfunction
endpackage

// File: rtl/edid_pin_map.sv
module edid_pin_map #(
  parameter int PORT_W = 2
) (
  input  logic [2:0]        pin_i,
  output logic              valid_o,
  output logic [PORT_W-1:0] port_o
);
  always_comb begin
    valid_o = 1'b1;
    port_o  = '0;
    unique case (pin_i)
      3'd5: port_o = PORT_W'(0);
      3'd4: port_o = PORT_W'(1);
      3'd6: port_o = PORT_W'(2);
      3'd2: port_o = PORT_W'(3);
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/edid_store.sv
module edid_store #(
  parameter int DEPTH = 128,
  parameter int LANES = 4,
  parameter int PTR_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  load_we_i,
  input  logic [AW-1:0]         load_addr_i,
  input  logic [7:0]            load_data_i,
  input  logic [PTR_W-1:0]      base_i,
  input  logic                  enable_i,
  output logic [LANES-1:0][7:0] lane_byte_o,
  output logic [LANES-1:0]      lane_ok_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (load_we_i) mem_q[load_addr_i] <= load_data_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PTR_W:0] pos;
    assign pos            = {1'b0, base_i} + (PTR_W+1)'(g);
    assign lane_ok_o[g]   = enable_i && (pos < (PTR_W+1)'(DEPTH));
    assign lane_byte_o[g] = lane_ok_o[g] ? mem_q[pos[AW-1:0]] : 8'h00;
  end
endmodule

// File: rtl/edid_regs_top.sv
module edid_regs_top
  import edid_i2c_pkg::*;
#(
  parameter int          EDID_BYTES  = 128,
  parameter int          NUM_PORTS   = 4,
  parameter int          DW          = 32,
  parameter logic [6:0]  TARGET_ADDR = 7'h50,
  localparam int         LANES       = DW / 8,
  localparam int         IDX_W       = $clog2(EDID_BYTES),
  localparam int         PORT_W      = $clog2(NUM_PORTS),
  localparam int         PTR_W       = 8,
  localparam int         CNT_W       = 9,
  localparam int         ADV_W       = $clog2(LANES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [1:0]           bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic [NUM_PORTS-1:0] monitor_present_i,
  input  logic                 load_we_i,
  input  logic [IDX_W-1:0]     load_addr_i,
  input  logic [7:0]           load_data_i
);
  logic [DW-1:0]    sel_q, sel_d, cmd_q, cmd_d, data_q, data_d, rdata_q, rdata_d;
  logic             active_q, active_d, wait_q, wait_d, timeout_q, timeout_d;
  logic             in_use_q, in_use_d;
  phase_e           phase_q, phase_d;
  logic             selected_q, selected_d, avail_q, avail_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [2:0]       cyc_q, cyc_d;

  logic             pin_valid;
  logic [PORT_W-1:0] pin_port;
  logic [LANES-1:0][7:0] lane_byte;
  logic [LANES-1:0] lane_ok;
  logic             has_rem;
  logic [CNT_W-1:0] rem;
  logic [DW-1:0]    status_word, cmd_w, packed_w;
  logic [ADV_W-1:0] adv;
  logic             init_edid;

  edid_pin_map #(.PORT_W(PORT_W)) i_pin_map (
    .pin_i   (bus_wdata_i[2:0]),
    .valid_o (pin_valid),
    .port_o  (pin_port)
  );

  edid_store #(.DEPTH(EDID_BYTES), .LANES(LANES), .PTR_W(PTR_W)) i_store (
    .clk_i       (clk_i),
    .load_we_i   (load_we_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .base_i      (ptr_q),
    .enable_i    (selected_q && avail_q),
    .lane_byte_o (lane_byte),
    .lane_ok_o   (lane_ok)
  );

  assign has_rem     = total_q > {1'b0, ptr_q};
  assign rem         = total_q - {1'b0, ptr_q};
  assign status_word = {{(DW-7){1'b0}}, phase_q, in_use_q, timeout_q, wait_q, active_q, 1'b1};
  assign bus_rdata_o = rdata_q;

  always_comb begin
    cmd_w = bus_wdata_i;
    cmd_w[CMD_SW_READY_BIT] = 1'b0;
    packed_w = data_q;
    adv = '0;
    for (int i = 0; i < LANES; i++) begin
      if (has_rem && rem > CNT_W'(i)) begin
        packed_w[8*i +: 8] = lane_byte[i];
        if (lane_ok[i]) adv = adv + ADV_W'(1);
      end
    end
  end

  always_comb begin
    sel_d = sel_q;  cmd_d = cmd_q;  data_d = data_q;  rdata_d = rdata_q;
    active_d = active_q;  wait_d = wait_q;  timeout_d = timeout_q;
    in_use_d = in_use_q;  phase_d = phase_q;
    selected_d = selected_q;  avail_d = avail_q;
    ptr_d = ptr_q;  total_d = total_q;  cyc_d = cyc_q;
    init_edid = 1'b0;
    if (bus_wr_i) begin
      unique case (bus_addr_i)
        REG_SEL: begin
          sel_d      = bus_wdata_i;
          selected_d = 1'b0;
          ptr_d      = '0;
          total_d    = '0;
          cyc_d      = CYC_NONE;
          phase_d    = PH_IDLE;
          avail_d    = 1'b0;
          if (pin_valid) begin
            active_d  = 1'b0;
            wait_d    = 1'b1;
            avail_d   = monitor_present_i[pin_port];
            timeout_d = !monitor_present_i[pin_port];
          end
        end
        REG_CMD: begin
          if (cmd_q[CMD_SW_CLR_BIT]) begin
            if (!bus_wdata_i[CMD_SW_CLR_BIT]) begin
              cmd_d[CMD_SW_CLR_BIT] = 1'b0;
              active_d  = 1'b0;
              wait_d    = 1'b0;
              in_use_d  = 1'b0;
              timeout_d = !avail_q;
              phase_d   = PH_IDLE;
            end
          end else begin
            total_d = cmd_w[CMD_CNT_LSB +: CNT_W];
            if (cmd_w[CMD_TGT_LSB +: 7] == TARGET_ADDR) selected_d = 1'b1;
            if (cmd_w[CMD_IDX_CYC_BIT]) ptr_d = cmd_w[CMD_IDX_LSB +: PTR_W];
            cyc_d = cmd_w[CMD_CYC_LSB +: 3];
            if (cyc_d == CYC_STOP) begin
              if (cmd_q[CMD_CYC_LSB +: 3] != CYC_NONE) begin
                init_edid = 1'b1;
                phase_d   = PH_IDLE;
                active_d  = 1'b0;
              end
            end else if (cyc_is_data(cyc_d)) begin
              phase_d  = PH_DATA;
              active_d = 1'b1;
            end
            cmd_d = cmd_w;
          end
        end
        REG_STAT: begin
          if (bus_wdata_i[ST_IN_USE_BIT]) in_use_d = 1'b0;
        end
        default: ;
      endcase
    end else if (bus_rd_i) begin
      unique case (bus_addr_i)
        REG_SEL:  rdata_d = sel_q;
        REG_CMD:  rdata_d = cmd_q;
        REG_STAT: begin
          rdata_d  = status_word;
          in_use_d = 1'b1;
        end
        default: begin
          if (cmd_q[CMD_DIR_BIT] && has_rem) begin
            data_d  = packed_w;
            rdata_d = packed_w;
            ptr_d   = ptr_q + PTR_W'(adv);
            if (rem <= CNT_W'(LANES)) begin
              phase_d   = cyc_ends_idle(cyc_q) ? PH_IDLE : PH_WAIT;
              init_edid = 1'b1;
            end
          end else begin
            rdata_d = data_q;
          end
        end
      endcase
    end
    if (init_edid) begin
      selected_d = 1'b0;
      avail_d    = 1'b0;
      ptr_d      = '0;
      total_d    = '0;
      cyc_d      = CYC_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;  cmd_q <= '0;  data_q <= '0;  rdata_q <= '0;
      active_q <= 1'b0;  wait_q <= 1'b0;  timeout_q <= 1'b1;  in_use_q <= 1'b0;
      phase_q <= PH_IDLE;
      selected_q <= 1'b0;  avail_q <= 1'b0;
      ptr_q <= '0;  total_q <= '0;  cyc_q <= CYC_NONE;
    end else begin
      sel_q <= sel_d;  cmd_q <= cmd_d;  data_q <= data_d;  rdata_q <= rdata_d;
      active_q <= active_d;  wait_q <= wait_d;  timeout_q <= timeout_d;
      in_use_q <= in_use_d;  phase_q <= phase_d;
      selected_q <= selected_d;  avail_q <= avail_d;
      ptr_q <= ptr_d;  total_q <= total_d;  cyc_q <= cyc_d;
    end
  end
endmodule

// File: rtl/edid_regs_chk.sv
module edid_regs_chk
  import edid_i2c_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_wr_i,
  input logic          bus_rd_i,
  input logic [1:0]    bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] data_q,
  input logic [DW-1:0] status_word,
  input logic          pin_valid
);
  // R4
  sw_ready_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_q[CMD_SW_READY_BIT]);

  // R13
  data_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == REG_DATA) |=> $stable(data_q));

  // R11
  in_use_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !bus_wr_i && bus_addr_i == REG_STAT) |=> status_word[ST_IN_USE_BIT]);

  // R11
  in_use_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == REG_STAT && bus_wdata_i[ST_IN_USE_BIT])
      |=> !status_word[ST_IN_USE_BIT]);

  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_i || bus_wr_i) |=> $stable(bus_rdata_o));

  // R3
  pin_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == REG_SEL && pin_valid)
      |=> (status_word[2] && !status_word[1] && status_word[6:5] == 2'd0));
endmodule

bind edid_regs_top edid_regs_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .cmd_q       (cmd_q),
  .data_q      (data_q),
  .status_word (status_word),
  .pin_valid   (pin_valid)
);

// File: tb/test_edid_regs_top.sv
`timescale 1ns/1ps
module test_edid_regs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  present = 4'b0101;
  logic        ld_we = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;

  always #2 clk = ~clk;

  edid_regs_top i_edid_regs_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .monitor_present_i(present),
    .load_we_i(ld_we), .load_addr_i(ld_addr), .load_data_i(ld_data)
  );

  int checks = 0, errors = 0;
  bit done = 0, live = 0;
  string cur_tag = "R1 reset";

  // behavioural reference
  int         m_mem [128];
  bit [31:0]  m_sel, m_cmd, m_data, m_rdata;
  bit         m_act, m_wait, m_to = 1, m_inuse, m_selected, m_avail;
  int         m_phase, m_ptr, m_total, m_cyc;

  function automatic int edid_val(int i);
    return (i * 37 + 11) % 256;
  endfunction

  function automatic bit [31:0] m_status();
    bit [1:0] ph = m_phase[1:0];
    return {25'b0, ph, m_inuse, m_to, m_wait, m_act, 1'b1};
  endfunction

  function automatic bit [31:0] mk_cmd(bit dir, int tgt, int idx, int cnt, int cyc);
    bit [31:0] c = 0;
    c[0] = dir; c[7:1] = tgt[6:0]; c[15:8] = idx[7:0]; c[24:16] = cnt[8:0]; c[27:25] = cyc[2:0];
    return c;
  endfunction

  task automatic m_init();
    m_selected = 0; m_avail = 0; m_ptr = 0; m_total = 0; m_cyc = 0;
  endtask

  task automatic m_write(int a, bit [31:0] v);
    int p; bit ok; int old;
    case (a)
      0: begin
        m_sel = v; m_init(); m_phase = 0;
        ok = 1;
        case (v[2:0]) 5: p = 0; 4: p = 1; 6: p = 2; 2: p = 3; default: ok = 0; endcase
        if (ok) begin
          m_act = 0; m_wait = 1; m_avail = present[p]; m_to = !present[p];
        end
      end
      1: begin
        if (m_cmd[31]) begin
          if (!v[31]) begin
            m_cmd[31] = 0; m_act = 0; m_wait = 0; m_inuse = 0; m_to = !m_avail; m_phase = 0;
          end
        end else begin
          v[30] = 0;
          m_total = v[24:16];
          if (v[7:1] == 7'h50) m_selected = 1;
          if (v[26]) m_ptr = v[15:8];
          old = m_cmd[27:25];
          m_cyc = v[27:25];
          if (m_cyc == 4) begin
            if (old != 0) begin m_init(); m_phase = 0; m_act = 0; end
          end else if (m_cyc % 2 == 1) begin
            m_phase = 1; m_act = 1;
          end
          m_cmd = v;
        end
      end
      2: if (v[4]) m_inuse = 0;
      default: ;
    endcase
  endtask

  task automatic m_read(int a);
    int n, left; int b;
    case (a)
      0: m_rdata = m_sel;
      1: m_rdata = m_cmd;
      2: begin m_rdata = m_status(); m_inuse = 1; end
      default: begin
        left = m_total - m_ptr;
        if (m_cmd[0] && left > 0) begin
          n = (left > 4) ? 4 : left;
          for (int i = 0; i < n; i++) begin
            if (m_selected && m_avail && m_ptr < 128) begin
              b = m_mem[m_ptr]; m_ptr++;
            end else b = 0;
            m_data[8*i +: 8] = b[7:0];
          end
          m_rdata = m_data;
          if (left <= 4) begin
            m_phase = (m_cyc == 5 || m_cyc == 7) ? 0 : 2;
            m_init();
          end
        end else m_rdata = m_data;
      end
    endcase
  endtask

  task automatic check(bit ok, string tag, bit [31:0] got, bit [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(int a, bit [31:0] v, string tag);
    @(negedge clk);
    cur_tag = tag; wr = 1; addr = a[1:0]; wdata = v;
    m_write(a, v);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic bus_rd(int a, string tag, output bit [31:0] got);
    @(negedge clk);
    cur_tag = tag; rd = 1; addr = a[1:0];
    m_read(a);
    @(negedge clk);
    rd = 0;
    got = rdata;
    check(got === m_rdata, tag, got, m_rdata);
  endtask

  // compare on every clock
  always @(posedge clk) begin
    #1;
    if (live && !done) check(rdata === m_rdata, {cur_tag, " per-clock R2"}, rdata, m_rdata);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [31:0] g, exp, s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_we = 1; ld_addr = i[6:0]; ld_data = edid_val(i)[7:0];
      m_mem[i] = edid_val(i);
    end
    @(negedge clk); ld_we = 0;

    bus_rd(2, "R1 reset status", g);
    check(g === 32'h09, "R1 reset status value", g, 32'h09);
    bus_rd(2, "R11 in-use after read", g);
    check(g === 32'h19, "R11 in-use value", g, 32'h19);
    bus_wr(2, 32'hFFFF_FFEF, "R11 status write no in-use bit");
    bus_rd(2, "R11 other status bits read-only", g);
    bus_wr(2, 32'h10, "R11 in-use clear");
    bus_rd(2, "R11 status after clear", g);
    check(g === 32'h09, "R11 cleared value", g, 32'h09);

    // indexed stop transfer of 10 bytes starting at 3
    bus_wr(0, 5, "R3 select present port");
    bus_rd(0, "R3 select readback", g);
    bus_rd(2, "R3 status after select", g);
    bus_wr(1, mk_cmd(1, 'h50, 3, 13, 7) | 32'h4000_0000, "R4 command write");
    bus_rd(1, "R4 sw-ready forced zero", g);
    check(g[30] === 1'b0, "R4 bit30 value", g, g & ~32'h4000_0000);
    bus_rd(2, "R6 data phase active", g);
    bus_rd(3, "R7 first word", g);
    exp = {edid_val(6)[7:0], edid_val(5)[7:0], edid_val(4)[7:0], edid_val(3)[7:0]};
    check(g === exp, "R5 R7 indexed word value", g, exp);
    bus_rd(3, "R7 second word", g);
    bus_rd(3, "R8 partial final word", g);
    bus_rd(2, "R8 stop cycle ends idle", g);
    bus_rd(3, "R10 nothing remaining", g);

    // no-stop transfer ends in wait
    bus_wr(0, 6, "R3 select second port");
    bus_wr(1, mk_cmd(1, 'h50, 0, 4, 1), "R6 data cycle no stop");
    bus_rd(3, "R7 four-byte word", g);
    bus_rd(2, "R8 wait phase", g);

    // absent display
    bus_wr(0, 4, "R3 absent display");
    bus_rd(2, "R3 timeout error set", g);
    bus_wr(1, mk_cmd(1, 'h50, 0, 4, 1), "R9 command absent");
    bus_rd(3, "R9 zero bytes when no EDID", g);
    check(g === 32'h0, "R9 absent value", g, 32'h0);
    bus_rd(2, "R8 status after absent read", g);

    // end of store
    bus_wr(0, 5, "R3 reselect");
    bus_wr(1, mk_cmd(1, 'h50, 126, 200, 3), "R5 index near end");
    bus_rd(3, "R9 end of store partial", g);
    exp = {16'h0, edid_val(127)[7:0], edid_val(126)[7:0]};
    check(g === exp, "R9 end value", g, exp);
    bus_rd(3, "R9 past end zeros", g);
    bus_rd(2, "R9 still data phase", g);
    bus_wr(1, mk_cmd(0, 0, 0, 0, 4), "R6 stop after data cycle");
    bus_rd(2, "R6 stop idles", g);

    // stop after stored no-cycle
    bus_wr(0, 5, "R3 reselect");
    bus_wr(1, mk_cmd(1, 'h50, 0, 8, 1), "R6 data cycle");
    bus_wr(1, mk_cmd(1, 'h50, 0, 8, 0), "R6 no cycle");
    bus_wr(1, mk_cmd(1, 'h50, 0, 8, 4), "R6 stop ignored");
    bus_rd(2, "R6 stop without prior cycle no effect", g);
    bus_wr(1, mk_cmd(1, 'h50, 0, 8, 2), "R6 reserved code");
    bus_rd(2, "R6 reserved code phase kept", g);

    // wrong target
    bus_wr(0, 5, "R3 reselect");
    bus_wr(1, mk_cmd(1, 'h37, 0, 4, 1), "R5 other target");
    bus_rd(3, "R5 other target zero data", g);

    // direction clear
    bus_wr(0, 5, "R3 reselect");
    bus_wr(1, mk_cmd(1, 'h50, 0, 8, 1), "R7 fill data");
    bus_rd(3, "R7 data fill", g);
    bus_wr(1, mk_cmd(0, 'h50, 0, 8, 1), "R10 write direction");
    bus_rd(3, "R10 direction clear returns last", g);

    // clear-interrupt handshake
    bus_wr(0, 5, "R3 reselect");
    bus_wr(1, mk_cmd(1, 'h50, 0, 8, 1) | 32'h8000_0000, "R12 set clear bit");
    bus_rd(1, "R12 command stored", g);
    s0 = g;
    bus_wr(1, mk_cmd(1, 'h50, 0, 20, 3) | 32'h8000_0000, "R12 write ignored");
    bus_rd(1, "R12 command unchanged", g);
    check(g === s0, "R12 unchanged value", g, s0);
    bus_rd(2, "R12 status before reset", g);
    bus_wr(1, 32'h0, "R12 release clear bit");
    bus_rd(2, "R12 controller reset status", g);
    check(g === 32'h01, "R12 reset status value", g, 32'h01);
    bus_rd(1, "R12 clear bit dropped", g);

    // data register writes
    bus_wr(1, mk_cmd(0, 'h50, 0, 0, 0), "R13 direction clear");
    bus_wr(3, 32'hDEAD_BEEF, "R13 data write");
    bus_rd(3, "R13 data write ignored", g);

    // invalid and zero pin codes
    bus_wr(0, 5, "R3 reselect");
    bus_rd(2, "R3 status before invalid", g);
    bus_wr(0, 3, "R3 invalid pin");
    bus_rd(2, "R3 invalid pin keeps flags", g);
    bus_wr(1, mk_cmd(1, 'h50, 0, 4, 1), "R3 command after invalid");
    bus_rd(3, "R3 invalid pin drops EDID", g);
    bus_wr(0, 0, "R3 zero pin");
    bus_rd(2, "R3 zero pin keeps flags", g);

    // write priority over read
    @(negedge clk);
    cur_tag = "R2 write priority"; wr = 1; rd = 1; addr = 2'd2; wdata = 32'h10;
    m_write(2, 32'h10);
    @(negedge clk);
    wr = 0; rd = 0;
    check(rdata === m_rdata, "R2 read ignored under write", rdata, m_rdata);
    bus_rd(2, "R2 status after priority", g);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule